// File: doc/BRIEF.md
# Keyboard Controller Command Decoder

This block interprets the single-byte commands a host writes to the command port of a keyboard controller. It also interprets the data bytes that follow on the data port. It holds the controller's mode byte, its output-port byte, the self-test flag and a register for a pending write command. Commands either answer at once with a response byte or change internal state. Some commands only arm the register, and the next data-port byte is then used according to the armed code. Response bytes go into the output queue through a push interface, and a select bit chooses the keyboard side or the auxiliary side. The block drives an address-line-20 gate level and a one-cycle system reset request.

Bytes meant for the keyboard or the auxiliary device leave as a strobe plus a byte. The serial transfer to those devices is handled elsewhere. Two status inputs report whether each output buffer is full, and the read-output-port answer uses them.

Top module: `kbc_cmd_decoder`

## Requirements
- R1: After reset all strobes (`q_push`, `kbd_tx_valid`, `aux_tx_valid`, `sys_reset_req`, `irq_recheck`) are low. `a20_gate` equals bit 1 of `OUTPORT_INIT`, the mode byte equals `MODE_INIT`, `selftest_done` is low and no command is armed.
- R2: Every response byte is presented on `q_push` for exactly one cycle, in the cycle after the write that caused it. `q_is_aux` = 0 selects the keyboard queue and 1 selects the auxiliary queue. At most one of `q_push`, `kbd_tx_valid` and `aux_tx_valid` is high in any cycle.
- R3: Command 0xAA answers 0x55, sets `selftest_done` (it never clears again before reset) and sets mode bit `KDIS_BIT` (default 4). Commands 0xA9 and 0xAB answer 0x00, and 0xC0 answers `INPORT_VALUE`.
- R4: 0x20 answers the mode byte. 0xAD sets mode bit `KDIS_BIT` and 0xAE clears it. 0xA7 sets mode bit `ADIS_BIT` (default 5) and 0xA8 clears it. 0xAE and 0xA8 also pulse `irq_recheck` for one cycle.
- R5: 0xE0 answers 0x01 while mode bit `KDIS_BIT` is clear and 0x00 while it is set.
- R6: 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 only arm the pending register. The next data byte goes to the mode byte (0x60), the keyboard queue (0xD2), the auxiliary queue (0xD3) or the auxiliary transmit strobe (0xD4). The pending register then returns to empty.
- R7: A data byte written while nothing is armed leaves on `kbd_tx_valid`/`kbd_tx_byte`.
- R8: 0xDF raises `a20_gate` and 0xDD lowers it. A data byte after 0xD1 becomes the output-port byte: `a20_gate` follows its bit 1, and a zero in its bit 0 pulses `sys_reset_req`.
- R9: 0xD0 answers 0x01 OR (`a20_gate` in bit 1) OR 0x10 when `kbd_obuf_full` is high OR 0x20 when `aux_obuf_full` is high.
- R10: A command with bits 7:4 = 0xF and bits 3:1 all ones is a pulse command. It pulses `sys_reset_req` for one cycle when bit 0 is 0 (0xFE) and does nothing when bit 0 is 1 (0xFF).
- R11: With `RAM_READ_ZERO` = 1, commands 0x21 through 0x3F answer 0x00.
- R12: Any other command byte produces no output and leaves the armed pending code in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_is_cmd | input | 1 | 1 = command port, 0 = data port |
| host_byte | input | DW | Byte written by the host |
| kbd_obuf_full | input | 1 | Keyboard output buffer holds a byte |
| aux_obuf_full | input | 1 | Auxiliary output buffer holds a byte |
| q_push | output | 1 | Push one byte into the output queue |
| q_is_aux | output | 1 | Queue select for the push |
| q_byte | output | DW | Byte pushed |
| kbd_tx_valid | output | 1 | Byte to be sent to the keyboard |
| kbd_tx_byte | output | DW | Keyboard transmit byte |
| aux_tx_valid | output | 1 | Byte to be sent to the auxiliary device |
| aux_tx_byte | output | DW | Auxiliary transmit byte |
| a20_gate | output | 1 | Address line 20 gate level |
| sys_reset_req | output | 1 | One-cycle system reset request |
| irq_recheck | output | 1 | One-cycle request to re-evaluate interrupts |
| selftest_done | output | 1 | Status self-test flag |

## Verification
The bench builds the block with `RAM_READ_ZERO` = 1, so the internal-RAM read window at 0x21 to 0x3F answers and its edges can be probed. It sets `INPORT_VALUE` to 0xA5 so the input-port answer is told apart from the zero answers. It keeps `OUTPORT_INIT` = 0x01 so that `a20_gate` starts low and every change to it comes from a command. With `KDIS_BIT` = 4 and `ADIS_BIT` = 5, mode reads after self-test and after the enable and disable commands show distinct values.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

   localparam logic [7:0] C_RD_MODE   = 8'h20;
   localparam logic [7:0] C_WR_MODE   = 8'h60;
   localparam logic [7:0] C_AUX_OFF   = 8'hA7;
   localparam logic [7:0] C_AUX_ON    = 8'hA8;
   localparam logic [7:0] C_AUX_TEST  = 8'hA9;
   localparam logic [7:0] C_SELFTEST  = 8'hAA;
   localparam logic [7:0] C_KBD_TEST  = 8'hAB;
   localparam logic [7:0] C_KBD_OFF   = 8'hAD;
   localparam logic [7:0] C_KBD_ON    = 8'hAE;
   localparam logic [7:0] C_RD_INPORT = 8'hC0;
   localparam logic [7:0] C_RD_OUTP   = 8'hD0;
   localparam logic [7:0] C_WR_OUTP   = 8'hD1;
   localparam logic [7:0] C_WR_KBUF   = 8'hD2;
   localparam logic [7:0] C_WR_ABUF   = 8'hD3;
   localparam logic [7:0] C_WR_AUXDEV = 8'hD4;
   localparam logic [7:0] C_A20_OFF   = 8'hDD;
   localparam logic [7:0] C_A20_ON    = 8'hDF;
   localparam logic [7:0] C_RD_TSTIN  = 8'hE0;
   localparam logic [7:0] C_NONE      = 8'h00;

   typedef enum logic [2:0] {
      RS_ZERO,
      RS_MODE,
      RS_SELFOK,
      RS_INPORT,
      RS_OUTPORT,
      RS_TESTIN
   } resp_src_e;

   typedef struct packed {
      logic      arm;
      logic      resp;
      resp_src_e src;
      logic      kdis_set;
      logic      kdis_clr;
      logic      adis_set;
      logic      adis_clr;
      logic      recheck;
      logic      a20_on;
      logic      a20_off;
      logic      sys_rst;
      logic      selftest;
   } cmd_dec_t;

endpackage

// File: rtl/kbc_cmd_classify.sv
module kbc_cmd_classify
   import kbc_pkg::*;
#(
   parameter int DW            = 8,
   parameter bit RAM_READ_ZERO = 1'b1
) (
   input  logic [DW-1:0] cmd,
   output cmd_dec_t      dec
);

   localparam logic [7:0] RAM_LO = 8'h21;
   localparam logic [7:0] RAM_HI = 8'h3F;

   logic ram_hit;
   logic pulse_hit;

   generate
      if (RAM_READ_ZERO) begin : g_ram_zero
         assign ram_hit = (cmd[7:0] >= RAM_LO) && (cmd[7:0] <= RAM_HI);
      end else begin : g_ram_ignore
         assign ram_hit = 1'b0;
      end
   endgenerate

   // pulse group: upper nibble F, bits 3..1 set; bit 0 selects reset or no-op
   assign pulse_hit = (cmd[7:4] == 4'hF) && (cmd[3:1] == 3'b111);

   always_comb begin
      dec     = '0;
      dec.src = RS_ZERO;
      unique case (cmd[7:0])
         C_RD_MODE:   begin dec.resp = 1'b1; dec.src = RS_MODE; end
         C_WR_MODE,
         C_WR_OUTP,
         C_WR_KBUF,
         C_WR_ABUF,
         C_WR_AUXDEV: dec.arm = 1'b1;
         C_AUX_OFF:   dec.adis_set = 1'b1;
         C_AUX_ON:    begin dec.adis_clr = 1'b1; dec.recheck = 1'b1; end
         C_AUX_TEST,
         C_KBD_TEST:  dec.resp = 1'b1;
         C_SELFTEST:  begin
            dec.resp     = 1'b1;
            dec.src      = RS_SELFOK;
            dec.selftest = 1'b1;
            dec.kdis_set = 1'b1;
         end
         C_KBD_OFF:   dec.kdis_set = 1'b1;
         C_KBD_ON:    begin dec.kdis_clr = 1'b1; dec.recheck = 1'b1; end
         C_RD_INPORT: begin dec.resp = 1'b1; dec.src = RS_INPORT; end
         C_RD_OUTP:   begin dec.resp = 1'b1; dec.src = RS_OUTPORT; end
         C_A20_OFF:   dec.a20_off = 1'b1;
         C_A20_ON:    dec.a20_on = 1'b1;
         C_RD_TSTIN:  begin dec.resp = 1'b1; dec.src = RS_TESTIN; end
         default: begin
            if (pulse_hit) begin
               dec.sys_rst = ~cmd[0];
            end else if (ram_hit) begin
               dec.resp = 1'b1;
            end
         end
      endcase
   end

endmodule

// File: rtl/kbc_ctrl_state.sv
module kbc_ctrl_state
   import kbc_pkg::*;
#(
   parameter int            DW           = 8,
   parameter logic [DW-1:0] MODE_INIT    = '0,
   parameter logic [DW-1:0] OUTPORT_INIT = 8'h01,
   parameter int            KDIS_BIT     = 4,
   parameter int            ADIS_BIT     = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_wr,
   input  logic          data_wr,
   input  logic [DW-1:0] wbyte,
   input  cmd_dec_t      dec,
   output logic [DW-1:0] mode_q,
   output logic [DW-1:0] outport_q,
   output logic [DW-1:0] pending_q,
   output logic          selftest_q
);

   localparam int A20_BIT = 1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q     <= MODE_INIT;
         outport_q  <= OUTPORT_INIT;
         pending_q  <= C_NONE;
         selftest_q <= 1'b0;
      end else if (cmd_wr) begin
         if (dec.arm)      pending_q <= wbyte;
         if (dec.kdis_set) mode_q[KDIS_BIT] <= 1'b1;
         if (dec.kdis_clr) mode_q[KDIS_BIT] <= 1'b0;
         if (dec.adis_set) mode_q[ADIS_BIT] <= 1'b1;
         if (dec.adis_clr) mode_q[ADIS_BIT] <= 1'b0;
         if (dec.selftest) selftest_q <= 1'b1;
         if (dec.a20_on)   outport_q[A20_BIT] <= 1'b1;
         if (dec.a20_off)  outport_q[A20_BIT] <= 1'b0;
      end else if (data_wr) begin
         if (pending_q == C_WR_MODE) mode_q    <= wbyte;
         if (pending_q == C_WR_OUTP) outport_q <= wbyte;
         pending_q <= C_NONE;
      end
   end

endmodule

// File: rtl/kbc_out_stage.sv
module kbc_out_stage
   import kbc_pkg::*;
#(
   parameter int            DW           = 8,
   parameter logic [DW-1:0] INPORT_VALUE = 8'hBF,
   parameter int            KDIS_BIT     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_wr,
   input  logic          data_wr,
   input  logic [DW-1:0] wbyte,
   input  cmd_dec_t      dec,
   input  logic [DW-1:0] pending,
   input  logic [DW-1:0] mode,
   input  logic          a20_now,
   input  logic          kbd_full,
   input  logic          aux_full,
   output logic          q_push,
   output logic          q_is_aux,
   output logic [DW-1:0] q_byte,
   output logic          kbd_tx_valid,
   output logic [DW-1:0] kbd_tx_byte,
   output logic          aux_tx_valid,
   output logic [DW-1:0] aux_tx_byte,
   output logic          sys_reset_req,
   output logic          irq_recheck
);

   logic [DW-1:0] resp_byte;
   logic [DW-1:0] outp_view;
   logic          n_push, n_aux, n_ktx, n_atx, n_rst, n_rechk;
   logic [DW-1:0] n_byte;

   always_comb begin
      outp_view    = '0;
      outp_view[0] = 1'b1;
      outp_view[1] = a20_now;
      outp_view[4] = kbd_full;
      outp_view[5] = aux_full;
   end

   always_comb begin
      unique case (dec.src)
         RS_MODE:    resp_byte = mode;
         RS_SELFOK:  resp_byte = 8'h55;
         RS_INPORT:  resp_byte = INPORT_VALUE;
         RS_OUTPORT: resp_byte = outp_view;
         RS_TESTIN:  resp_byte = {{(DW-1){1'b0}}, ~mode[KDIS_BIT]};
         default:    resp_byte = '0;
      endcase
   end

   always_comb begin
      n_push  = 1'b0;
      n_aux   = 1'b0;
      n_ktx   = 1'b0;
      n_atx   = 1'b0;
      n_rst   = 1'b0;
      n_rechk = 1'b0;
      n_byte  = wbyte;
      if (cmd_wr) begin
         n_push  = dec.resp;
         n_byte  = resp_byte;
         n_rst   = dec.sys_rst;
         n_rechk = dec.recheck;
      end else if (data_wr) begin
         unique case (pending)
            C_WR_KBUF:   n_push = 1'b1;
            C_WR_ABUF:   begin n_push = 1'b1; n_aux = 1'b1; end
            C_WR_AUXDEV: n_atx = 1'b1;
            C_WR_OUTP:   n_rst = ~wbyte[0];
            C_NONE:      n_ktx = 1'b1;
            default:     ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_push        <= 1'b0;
         q_is_aux      <= 1'b0;
         q_byte        <= '0;
         kbd_tx_valid  <= 1'b0;
         kbd_tx_byte   <= '0;
         aux_tx_valid  <= 1'b0;
         aux_tx_byte   <= '0;
         sys_reset_req <= 1'b0;
         irq_recheck   <= 1'b0;
      end else begin
         q_push        <= n_push;
         q_is_aux      <= n_aux;
         kbd_tx_valid  <= n_ktx;
         aux_tx_valid  <= n_atx;
         sys_reset_req <= n_rst;
         irq_recheck   <= n_rechk;
         if (n_push) q_byte      <= n_byte;
         if (n_ktx)  kbd_tx_byte <= wbyte;
         if (n_atx)  aux_tx_byte <= wbyte;
      end
   end

endmodule

// File: rtl/kbc_cmd_decoder.sv
module kbc_cmd_decoder
   import kbc_pkg::*;
#(
   parameter int            DW            = 8,
   parameter logic [DW-1:0] MODE_INIT     = '0,
   parameter logic [DW-1:0] OUTPORT_INIT  = 8'h01,
   parameter logic [DW-1:0] INPORT_VALUE  = 8'hBF,
   parameter int            KDIS_BIT      = 4,
   parameter int            ADIS_BIT      = 5,
   parameter bit            RAM_READ_ZERO = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_wr,
   input  logic          host_is_cmd,
   input  logic [DW-1:0] host_byte,
   input  logic          kbd_obuf_full,
   input  logic          aux_obuf_full,
   output logic          q_push,
   output logic          q_is_aux,
   output logic [DW-1:0] q_byte,
   output logic          kbd_tx_valid,
   output logic [DW-1:0] kbd_tx_byte,
   output logic          aux_tx_valid,
   output logic [DW-1:0] aux_tx_byte,
   output logic          a20_gate,
   output logic          sys_reset_req,
   output logic          irq_recheck,
   output logic          selftest_done
);

   generate
      if (DW != 8) begin : g_bad_width
         $error("kbc_cmd_decoder: DW must be 8");
      end
      if (KDIS_BIT == ADIS_BIT || KDIS_BIT >= DW || ADIS_BIT >= DW) begin : g_bad_bits
         $error("kbc_cmd_decoder: disable bit positions invalid");
      end
   endgenerate

   cmd_dec_t      dec;
   logic          cmd_wr, data_wr;
   logic [DW-1:0] mode_q, outport_q, pending_q;

   assign cmd_wr   = host_wr &  host_is_cmd;
   assign data_wr  = host_wr & ~host_is_cmd;
   assign a20_gate = outport_q[1];

   kbc_cmd_classify #(
      .DW(DW), .RAM_READ_ZERO(RAM_READ_ZERO)
   ) u_classify (
      .cmd (host_byte),
      .dec (dec)
   );

   kbc_ctrl_state #(
      .DW(DW), .MODE_INIT(MODE_INIT), .OUTPORT_INIT(OUTPORT_INIT),
      .KDIS_BIT(KDIS_BIT), .ADIS_BIT(ADIS_BIT)
   ) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wr     (cmd_wr),
      .data_wr    (data_wr),
      .wbyte      (host_byte),
      .dec        (dec),
      .mode_q     (mode_q),
      .outport_q  (outport_q),
      .pending_q  (pending_q),
      .selftest_q (selftest_done)
   );

   kbc_out_stage #(
      .DW(DW), .INPORT_VALUE(INPORT_VALUE), .KDIS_BIT(KDIS_BIT)
   ) u_out (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_wr        (cmd_wr),
      .data_wr       (data_wr),
      .wbyte         (host_byte),
      .dec           (dec),
      .pending       (pending_q),
      .mode          (mode_q),
      .a20_now       (outport_q[1]),
      .kbd_full      (kbd_obuf_full),
      .aux_full      (aux_obuf_full),
      .q_push        (q_push),
      .q_is_aux      (q_is_aux),
      .q_byte        (q_byte),
      .kbd_tx_valid  (kbd_tx_valid),
      .kbd_tx_byte   (kbd_tx_byte),
      .aux_tx_valid  (aux_tx_valid),
      .aux_tx_byte   (aux_tx_byte),
      .sys_reset_req (sys_reset_req),
      .irq_recheck   (irq_recheck)
   );

endmodule

// File: rtl/kbc_cmd_decoder_chk.sv
module kbc_cmd_decoder_chk (
   input logic clk,
   input logic rst_n,
   input logic host_wr,
   input logic host_is_cmd,
   input logic q_push,
   input logic kbd_tx_valid,
   input logic aux_tx_valid,
   input logic a20_gate,
   input logic sys_reset_req,
   input logic irq_recheck,
   input logic selftest_done
);

   assert_one_channel_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({q_push, kbd_tx_valid, aux_tx_valid}));

   assert_push_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      q_push |-> $past(host_wr));

   assert_selftest_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(selftest_done));

   assert_recheck_after_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_recheck |-> $past(host_wr && host_is_cmd));

   assert_kbd_tx_after_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      kbd_tx_valid |-> $past(host_wr && !host_is_cmd));

   assert_a20_moves_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(host_wr) |-> $stable(a20_gate));

   assert_reset_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset_req |=> !sys_reset_req);

endmodule

bind kbc_cmd_decoder kbc_cmd_decoder_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .host_wr       (host_wr),
   .host_is_cmd   (host_is_cmd),
   .q_push        (q_push),
   .kbd_tx_valid  (kbd_tx_valid),
   .aux_tx_valid  (aux_tx_valid),
   .a20_gate      (a20_gate),
   .sys_reset_req (sys_reset_req),
   .irq_recheck   (irq_recheck),
   .selftest_done (selftest_done)
);

// File: tb/sim_kbc_cmd_decoder.sv
module sim_kbc_cmd_decoder;

   localparam logic [7:0] INP = 8'hA5;
   // scoreboard item kinds
   localparam logic [1:0] K_KQ = 2'd0, K_AQ = 2'd1, K_KTX = 2'd2, K_ATX = 2'd3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0;
   logic       host_is_cmd = 1'b0;
   logic [7:0] host_byte = '0;
   logic       kbd_obuf_full = 1'b0;
   logic       aux_obuf_full = 1'b0;
   logic       q_push, q_is_aux, kbd_tx_valid, aux_tx_valid;
   logic [7:0] q_byte, kbd_tx_byte, aux_tx_byte;
   logic       a20_gate, sys_reset_req, irq_recheck, selftest_done;

   int nchk = 0, nfail = 0, rst_cnt = 0, rechk_cnt = 0;
   bit done = 1'b0;
   logic [9:0] exp_q[$];

   always #10 clk = ~clk;

   kbc_cmd_decoder #(
      .INPORT_VALUE(INP), .OUTPORT_INIT(8'h01), .RAM_READ_ZERO(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_is_cmd(host_is_cmd),
      .host_byte(host_byte), .kbd_obuf_full(kbd_obuf_full),
      .aux_obuf_full(aux_obuf_full), .q_push(q_push), .q_is_aux(q_is_aux),
      .q_byte(q_byte), .kbd_tx_valid(kbd_tx_valid), .kbd_tx_byte(kbd_tx_byte),
      .aux_tx_valid(aux_tx_valid), .aux_tx_byte(aux_tx_byte),
      .a20_gate(a20_gate), .sys_reset_req(sys_reset_req),
      .irq_recheck(irq_recheck), .selftest_done(selftest_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
      end
   endtask

   task automatic wr(input bit is_cmd, input logic [7:0] b);
      @(negedge clk);
      host_wr = 1'b1; host_is_cmd = is_cmd; host_byte = b;
      @(negedge clk);
      host_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic expect_item(input logic [1:0] k, input logic [7:0] b);
      exp_q.push_back({k, b});
   endtask

   // monitor: pops expected items as the design produces them
   always @(negedge clk) begin
      if (rst_n) begin
         logic [9:0] got;
         bit any;
         any = 1'b1;
         if (q_push)            got = {(q_is_aux ? K_AQ : K_KQ), q_byte};
         else if (kbd_tx_valid) got = {K_KTX, kbd_tx_byte};
         else if (aux_tx_valid) got = {K_ATX, aux_tx_byte};
         else                   any = 1'b0;
         if (any) begin
            if (exp_q.size() == 0) chk(1'b0, "R2 unexpected output", int'(got), 0);
            else begin
               logic [9:0] e;
               e = exp_q.pop_front();
               chk(got == e, "R2 scoreboard item", int'(got), int'(e));
            end
         end
         if (sys_reset_req) rst_cnt++;
         if (irq_recheck)   rechk_cnt++;
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 20000);
      nchk++; nfail++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!q_push && !kbd_tx_valid && !aux_tx_valid, "R1 strobes idle", q_push, 0);
      chk(a20_gate == 1'b0, "R1 a20 init", a20_gate, 0);
      chk(selftest_done == 1'b0, "R1 selftest clear", selftest_done, 0);
      chk(sys_reset_req == 1'b0 && irq_recheck == 1'b0, "R1 pulses idle", sys_reset_req, 0);
      expect_item(K_KQ, 8'h00); wr(1, 8'h20);              // R1 mode init
      // R5 test inputs while enabled
      expect_item(K_KQ, 8'h01); wr(1, 8'hE0);
      // R3 self-test
      expect_item(K_KQ, 8'h55); wr(1, 8'hAA);
      chk(selftest_done == 1'b1, "R3 selftest flag", selftest_done, 1);
      expect_item(K_KQ, 8'h10); wr(1, 8'h20);
      expect_item(K_KQ, 8'h00); wr(1, 8'hE0);              // R5 disabled
      // R4 enables and disables
      wr(1, 8'hAE);
      chk(rechk_cnt == 1, "R4 recheck on kbd enable", rechk_cnt, 1);
      expect_item(K_KQ, 8'h00); wr(1, 8'h20);
      wr(1, 8'hA7);
      expect_item(K_KQ, 8'h20); wr(1, 8'h20);
      wr(1, 8'hA8);
      chk(rechk_cnt == 2, "R4 recheck on aux enable", rechk_cnt, 2);
      wr(1, 8'hAD);
      expect_item(K_KQ, 8'h10); wr(1, 8'h20);
      wr(1, 8'hAE);
      // R3 fixed answers
      expect_item(K_KQ, 8'h00); wr(1, 8'hA9);
      expect_item(K_KQ, 8'h00); wr(1, 8'hAB);
      expect_item(K_KQ, INP);   wr(1, 8'hC0);
      // R6 write mode
      wr(1, 8'h60); wr(0, 8'h45);
      expect_item(K_KQ, 8'h45); wr(1, 8'h20);
      wr(1, 8'h60); wr(0, 8'h00);
      // R7 plain data
      expect_item(K_KTX, 8'h77); wr(0, 8'h77);
      // R6 buffer writes and aux forwarding
      wr(1, 8'hD2); expect_item(K_KQ, 8'h9C); wr(0, 8'h9C);
      wr(1, 8'hD3); expect_item(K_AQ, 8'h3A); wr(0, 8'h3A);
      wr(1, 8'hD4); expect_item(K_ATX, 8'hF4); wr(0, 8'hF4);
      expect_item(K_KTX, 8'h11); wr(0, 8'h11);             // R6 latch cleared
      // R12 unknown command keeps armed code
      wr(1, 8'hD2); wr(1, 8'h05); wr(1, 8'h40);
      expect_item(K_KQ, 8'h66); wr(0, 8'h66);
      // R8 / R9 a20 and output-port read
      wr(1, 8'hDF);
      chk(a20_gate == 1'b1, "R8 a20 on", a20_gate, 1);
      kbd_obuf_full = 1'b1;
      expect_item(K_KQ, 8'h13); wr(1, 8'hD0);
      kbd_obuf_full = 1'b0; aux_obuf_full = 1'b1;
      expect_item(K_KQ, 8'h23); wr(1, 8'hD0);
      aux_obuf_full = 1'b0;
      wr(1, 8'hDD);
      chk(a20_gate == 1'b0, "R8 a20 off", a20_gate, 0);
      expect_item(K_KQ, 8'h01); wr(1, 8'hD0);              // R9 idle view
      wr(1, 8'hD1); wr(0, 8'h02);
      chk(a20_gate == 1'b1, "R8 outport a20 bit", a20_gate, 1);
      chk(rst_cnt == 1, "R8 outport bit0 low resets", rst_cnt, 1);
      wr(1, 8'hD1); wr(0, 8'h01);
      chk(a20_gate == 1'b0, "R8 outport a20 clear", a20_gate, 0);
      chk(rst_cnt == 1, "R8 outport bit0 high no reset", rst_cnt, 1);
      // R10 pulse commands
      wr(1, 8'hFE);
      chk(rst_cnt == 2, "R10 0xFE resets", rst_cnt, 2);
      wr(1, 8'hFF);
      chk(rst_cnt == 2, "R10 0xFF no-op", rst_cnt, 2);
      // R11 internal RAM reads
      expect_item(K_KQ, 8'h00); wr(1, 8'h21);
      expect_item(K_KQ, 8'h00); wr(1, 8'h3F);
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R2 all items seen", exp_q.size(), 0);
      finish_run();
   end

endmodule